// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus. It gives a host access to a bank of eight 8-bit control registers. Both wires are open drain. The block samples them with a fast system clock and pulls SDA low through a single output enable. The bank is also presented in parallel to the surrounding logic, and three read-only bits of it come from strap inputs latched outside the block.

Two transfer forms are accepted, both addressed to 7-bit address 0x69.

- **Write.** The address byte 0xD2 is followed by a start index and a byte count, and then by that many data bytes. The data bytes land in consecutive registers starting at the index.
- **Read.** The host first sets the index with 0xD2, then issues a repeated start and 0xD3. The block answers with the byte count and then with consecutive registers, until the host withholds its acknowledge.

Top module: `smb_idxblk_target`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal 0x69. Bit 0 selects a write when 0 and a read when 1, so the two valid address bytes are 0xD2 and 0xD3. On any other address no ACK is driven, and SDA stays released until the next start.
- R2: In a write, the byte after the address is the start index N and the next one is the count X. The X data bytes that follow are each acknowledged and stored in registers N, N+1, and so on.
- R3: A data byte that arrives after X data bytes have already been taken is not acknowledged and is not stored. The transfer is then dropped until the next start.
- R4: A read is entered with address 0xD3, normally after a repeated start that follows an index write. The first byte sent is the count 8 (0x08). After it come registers N, N+1, and so on. Each host ACK requests the next byte. A host NACK ends the read, and SDA stays released.
- R5: Reset values:

  | Register | Reset value |
  |---|---|
  | 0 | 0xFF |
  | 1 | 0xFE |
  | 2 | 0xFF |
  | 3 | 0x00 |
  | 4 | 0x07 |
  | 5 | 0x00 |
  | 6 | 0x18 with bits 2:0 equal to the strap inputs |
  | 7 | 0x11 (revision in bits 7:4, vendor in bits 3:0) |

- R6: Writes never change the read-only and reserved bits listed below. In every register the writable bits are the remaining ones. Register 6 bits 2:0 always show the present strap inputs.

  | Register | Bits writes leave unchanged |
  |---|---|
  | 1 | bit 3 |
  | 2 | bits 3:1 |
  | 4 | bits 7 and 5 |
  | 6 | bits 5 and 2:0 |
  | 7 | all bits |

- R7: A register index of 8 or above (start index or incremented pointer) selects no register. Writes there are acknowledged but discarded, and reads there return 0x00.
- R8: A stop, or a start, seen in the middle of a byte aborts the transfer, and the partial byte is not stored. A start always begins a fresh address phase.
- R9: The SDA pull-down changes only while SCL is low, and it is released after a stop.
- R10: The parallel register view changes only as the result of a completed, acknowledged data byte, apart from the strap bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Latched strap value shown in register 6 bits 2:0 |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 64 | Register bank view; register i occupies bits 8i+7:8i |

## Verification
The cases hardest to reach from the pins are the abort paths:

- A stop or start that falls inside a data byte.
- A byte that arrives after the count is used up.

Both leave the target in the middle of its bit sequence. The bench therefore drives the bus bit by bit through host tasks that can stop after any number of bits and then issue a stop or a repeated start. It then confirms at the register view that nothing was stored, and that a clean transfer right afterwards still works. A reference copy of the register bank is compared with the parallel view on every clock between transfers, so a write that lands in the wrong place or at the wrong moment is caught even if it is later overwritten.

// File: rtl/smb_idxblk_pkg.sv
package smb_idxblk_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned STRAP_W   = 3;
  localparam int unsigned STRAP_REG = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_TX,
    ST_TX,
    ST_ACK_RX,
    ST_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_INDEX,
    RK_COUNT,
    RK_DATA
  } rx_kind_e;

  // power-on contents of each register (strap bits of register 6 held at zero)
  function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
    case (idx)
      0: return 8'hFF;
      1: return 8'hFE;
      2: return 8'hFF;
      4: return 8'h07;
      6: return 8'h18;
      7: return 8'h11;
      default: return 8'h00;
    endcase
  endfunction

  // bits a host write may change
  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    case (idx)
      0: return 8'hFF;
      1: return 8'hF7;
      2: return 8'hF1;
      3: return 8'hFF;
      4: return 8'h5F;
      5: return 8'hFF;
      6: return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] masked_merge(input logic [BYTE_W-1:0] old_v,
                                                     input logic [BYTE_W-1:0] new_v,
                                                     input logic [BYTE_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic addr_match(input logic [BYTE_W-1:0] addr_byte,
                                      input logic [6:0] dev);
    return addr_byte[7:1] == dev;
  endfunction

  function automatic logic in_bank(input logic [BYTE_W-1:0] ptr, input int unsigned n);
    return 32'(ptr) < n;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_idxblk_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [BYTE_W-1:0]          rd_idx,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  localparam logic [BYTE_W-1:0] STRAP_MASK = BYTE_W'((1 << STRAP_W) - 1);

  logic [BYTE_W-1:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reg_reset(g);
      else if (wr_en && (32'(wr_idx) == g))
        q <= masked_merge(q, wr_data, reg_wmask(g));
    end

    if (g == STRAP_REG) begin : g_strap
      assign view[g] = (q & ~STRAP_MASK) | {{(BYTE_W-STRAP_W){1'b0}}, strap_i};
    end else begin : g_plain
      assign view[g] = q;
    end

    assign regs_o[g*BYTE_W +: BYTE_W] = view[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (32'(rd_idx) == i) rd_data = view[i];
  end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_idxblk_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ignoring
);

  localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);

  phase_e            ph;
  rx_kind_e          kind;
  logic [BYTE_W-1:0] shreg, ptr, left;
  logic [3:0]        bitcnt;
  logic              rd_mode, host_ack;
  logic              byte_done;

  assign byte_done = (ph == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign wr_en     = byte_done && (kind == RK_DATA) && (left != '0) && in_bank(ptr, NUM_REGS);
  assign wr_idx    = ptr[IDX_W-1:0];
  assign wr_data   = shreg;
  assign rd_idx    = ptr;
  assign ignoring  = (ph == ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= ST_IDLE;
      kind     <= RK_ADDR;
      shreg    <= '0;
      ptr      <= '0;
      left     <= '0;
      bitcnt   <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (ev_start) begin
      ph     <= ST_RX;
      kind   <= RK_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      ph     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (ph)
        ST_RX: begin
          if (scl_rise && (bitcnt != 4'd8)) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            unique case (kind)
              RK_ADDR: begin
                if (addr_match(shreg, DEV_ADDR)) begin
                  rd_mode <= shreg[0];
                  kind    <= RK_INDEX;
                  sda_oe  <= 1'b1;
                  ph      <= ST_ACK_TX;
                end else begin
                  ph <= ST_IGNORE;
                end
              end
              RK_INDEX: begin
                ptr    <= shreg;
                kind   <= RK_COUNT;
                sda_oe <= 1'b1;
                ph     <= ST_ACK_TX;
              end
              RK_COUNT: begin
                left   <= shreg;
                kind   <= RK_DATA;
                sda_oe <= 1'b1;
                ph     <= ST_ACK_TX;
              end
              RK_DATA: begin
                if (left != '0) begin
                  ptr    <= ptr + 8'd1;
                  left   <= left - 8'd1;
                  sda_oe <= 1'b1;
                  ph     <= ST_ACK_TX;
                end else begin
                  ph <= ST_IGNORE;
                end
              end
              default: ph <= ST_IGNORE;
            endcase
          end
        end
        ST_ACK_TX: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              shreg   <= COUNT_BYTE;
              sda_oe  <= ~COUNT_BYTE[BYTE_W-1];
              rd_mode <= 1'b0;
              ph      <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              ph     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              ph     <= ST_ACK_RX;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_ACK_RX: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr + 8'd1;
              bitcnt <= '0;
              ph     <= ST_TX;
            end else begin
              ph <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smb_idxblk_target.sv
module smb_idxblk_target
  import smb_idxblk_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic              wr_en, ignoring;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data, rd_idx, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  smb_proto_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe_o),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .ignoring (ignoring)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .strap_i (strap_i),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/smb_idxblk_chk.sv
module smb_idxblk_chk #(
  parameter int unsigned NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  ev_start,
  input logic                  ev_stop,
  input logic                  ignoring,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] regs
);

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  a_r1_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  a_r6_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    regs[7*8 +: 8] == 8'h11);

  a_r10_view_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs[6*8-1:0]));

endmodule

bind smb_idxblk_target smb_idxblk_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe_o),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .ignoring (ignoring),
  .wr_en    (wr_en),
  .regs     (regs_o)
);

// File: tb/smb_idxblk_target_tb_top.sv
`timescale 1ns/1ps
module smb_idxblk_target_tb_top;

  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_h_low = 1'b0;
  logic        sda_h_low = 1'b0;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe;
  logic [63:0] regs_o;
  wire         scl = !scl_h_low;
  wire         sda = !(sda_h_low | sda_oe);

  always #2.5 clk = ~clk;

  smb_idxblk_target dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .regs_o   (regs_o)
  );

  logic [7:0] mdl [8];
  bit         mdl_valid = 0;
  bit         done = 0;
  int         errs = 0, checks = 0, mism = 0, glitch = 0, oe_seen = 0, cyc = 0;
  logic       oe_prev = 1'b0;

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0, 3, 5: return 8'hFF;
      1: return 8'hF7;
      2: return 8'hF1;
      4: return 8'h5F;
      6: return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] mdl_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++)
      f[i*8 +: 8] = (i == 6) ? ((mdl[6] & 8'hF8) | {5'b0, strap}) : mdl[i];
    return f;
  endfunction

  task automatic apply_write(input int idx, input logic [7:0] v);
    if (idx < 8) mdl[idx] = (mdl[idx] & ~wmask(idx)) | (v & wmask(idx));
  endtask

  // per-clock comparison against the reference bank, plus bus-rule monitors
  always @(negedge clk) begin
    if (rst_n && mdl_valid && regs_o !== mdl_flat()) mism++;
    if (rst_n && scl && (sda_oe !== oe_prev)) glitch++;
    if (sda_oe) oe_seen++;
    oe_prev = sda_oe;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_view(input string tag);
    chk(mism == 0 && regs_o === mdl_flat(), tag, regs_o, mdl_flat());
    mism = 0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h_low = 0; hold(H);
    scl_h_low = 0; hold(H);
    sda_h_low = 1; hold(H);
    scl_h_low = 1; hold(H);
  endtask

  task automatic bus_stop();
    sda_h_low = 1; hold(H);
    scl_h_low = 0; hold(H);
    sda_h_low = 0; hold(H);
  endtask

  task automatic send_bit(input logic b);
    sda_h_low = !b; hold(H);
    scl_h_low = 0;  hold(H);
    scl_h_low = 1;  hold(2);
  endtask

  task automatic recv_bit(output logic b);
    sda_h_low = 0;  hold(H);
    scl_h_low = 0;  hold(H/2);
    b = sda;        hold(H/2);
    scl_h_low = 1;  hold(2);
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!ack);
  endtask

  initial begin
    bit         a;
    logic [7:0] rb;
    logic [7:0] wd [3];
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[0] = 8'hFF; mdl[1] = 8'hFE; mdl[2] = 8'hFF; mdl[4] = 8'h07;
    mdl[6] = 8'h18; mdl[7] = 8'h11;
    hold(10);
    rst_n = 1;
    hold(5);
    mdl_valid = 1;

    // reset contents
    chk(regs_o === 64'h111D_0007_00FF_FEFF, "R5 reset view", regs_o, 64'h111D_0007_00FF_FEFF);
    chk(sda_oe === 1'b0, "R9 idle release", {63'b0, sda_oe}, 64'd0);

    // block write of three registers starting at 0
    mdl_valid = 0;
    wd[0] = 8'hA5; wd[1] = 8'h30; wd[2] = 8'h80;
    bus_start();
    write_byte(8'hD2, a); chk(a, "R1 own write address ack", {63'b0, a}, 64'd1);
    write_byte(8'h00, a); chk(a, "R2 index ack", {63'b0, a}, 64'd1);
    write_byte(8'h03, a); chk(a, "R2 count ack", {63'b0, a}, 64'd1);
    for (int i = 0; i < 3; i++) begin
      write_byte(wd[i], a);
      chk(a, "R2 data ack", {63'b0, a}, 64'd1);
      apply_write(i, wd[i]);
    end
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R2 R6 block write from index 0");

    // write into registers 5..7: read-only fields must survive
    mdl_valid = 0;
    wd[0] = 8'h5A; wd[1] = 8'hFF; wd[2] = 8'h00;
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h05, a); write_byte(8'h03, a);
    for (int i = 0; i < 3; i++) begin
      write_byte(wd[i], a);
      chk(a, "R6 data ack", {63'b0, a}, 64'd1);
      apply_write(5 + i, wd[i]);
    end
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R6 read-only bits kept");

    // bytes beyond the count
    mdl_valid = 0;
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h03, a); write_byte(8'h02, a);
    write_byte(8'h3C, a); chk(a, "R3 first in count", {63'b0, a}, 64'd1); apply_write(3, 8'h3C);
    write_byte(8'hFF, a); chk(a, "R3 last in count", {63'b0, a}, 64'd1); apply_write(4, 8'hFF);
    write_byte(8'h77, a); chk(!a, "R3 extra byte nack", {63'b0, a}, 64'd0);
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R3 extra byte not stored");

    // pointer running past the bank
    mdl_valid = 0;
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h07, a); write_byte(8'h03, a);
    write_byte(8'h00, a);
    write_byte(8'h99, a); chk(a, "R7 ack at index 8", {63'b0, a}, 64'd1);
    write_byte(8'h66, a); chk(a, "R7 ack at index 9", {63'b0, a}, 64'd1);
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R7 out-of-bank writes discarded");

    // foreign address
    oe_seen = 0;
    bus_start();
    write_byte(8'hA0, a); chk(!a, "R1 foreign address nack", {63'b0, a}, 64'd0);
    write_byte(8'h00, a);
    write_byte(8'h01, a);
    bus_stop();
    chk(oe_seen == 0, "R1 bus ignored", 64'(oe_seen), 64'd0);
    chk_view("R1 no write from foreign address");

    // indexed read through repeated start
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h02, a);
    bus_start();
    write_byte(8'hD3, a); chk(a, "R1 own read address ack", {63'b0, a}, 64'd1);
    read_byte(rb, 1'b1); chk(rb == 8'h08, "R4 count byte", 64'(rb), 64'h08);
    for (int i = 2; i < 8; i++) begin
      logic [63:0] f;
      f = mdl_flat();
      read_byte(rb, 1'b1);
      chk(rb == f[i*8 +: 8], "R4 register data", 64'(rb), 64'(f[i*8 +: 8]));
    end
    read_byte(rb, 1'b0); chk(rb == 8'h00, "R7 read past bank", 64'(rb), 64'h00);
    hold(5);
    chk(sda_oe === 1'b0, "R4 released after nack", {63'b0, sda_oe}, 64'd0);
    bus_stop();
    hold(5);
    chk(sda_oe === 1'b0, "R9 released after stop", {63'b0, sda_oe}, 64'd0);

    // stop inside a data byte
    mdl_valid = 0;
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h00, a); write_byte(8'h02, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R8 stop mid-byte");

    // start inside a data byte, then a fresh transfer
    mdl_valid = 0;
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h01, a); write_byte(8'h01, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    write_byte(8'hD2, a); chk(a, "R8 address after restart", {63'b0, a}, 64'd1);
    write_byte(8'h00, a); write_byte(8'h01, a);
    write_byte(8'h5A, a); chk(a, "R8 data after restart", {63'b0, a}, 64'd1);
    apply_write(0, 8'h5A);
    bus_stop();
    hold(4);
    mdl_valid = 1;
    hold(4);
    chk_view("R8 abort then clean write");

    // strap inputs follow through
    mdl_valid = 0;
    hold(1);
    strap = 3'b010;
    hold(3);
    mdl_valid = 1;
    hold(5);
    chk_view("R6 strap bits follow input");

    hold(20);
    chk(glitch == 0, "R9 pull-down change under high SCL", 64'(glitch), 64'd0);
    chk_view("R10 view stable between transfers");

    done = 1;
    summary();
    $finish;
  end

endmodule